// File: doc/BRIEF.md
# Indirect Processor Register Port for a Channel Switch

This block is the processor-facing side of a time-slot switch. A host reaches it through a small asynchronous-style slave bus. The bus has a 6-bit address, separate write and read data paths with a read-drive enable, an active-high strobe, an active-low select and a read/not-write line. The block answers each transfer with an active-low acknowledge. The host never addresses the switch memories directly. Instead it first loads an 8-bit control byte that names a stream and a target memory, and then addresses one of 32 channels inside that stream.

Transfers that need a memory are forwarded over a request/grant port to the memory scheduler, which owns the data memory and the two connection memories. The scheduler grants the request in its processor slot. A control-byte access, or a transfer that names no usable memory, completes locally after a single clock. The control byte also carries a global message-mode flag, which leaves the block on its own output. It also carries a split mode, in which every memory read is served by the data memory and every memory write goes to the low connection memory.

Top module: `cpu_port_ctl`

## Requirements
- R1: With address bit 5 at 0, the transfer targets the control byte whatever address bits 4..0 hold. A read returns the stored byte with bit 5 always 0.
- R2: A control-byte write takes effect at once. Fields: bits 2..0 stream, bits 4..3 memory select, bit 6 message mode, bit 7 split. Acknowledge falls one clock after the transfer is seen, and no memory request is raised.
- R3: With address bit 5 at 1, the memory address is {stream, address bits 4..0}. The memory select is driven as 01 for data memory, 10 for connection-low and 11 for connection-high.
- R4: With the split bit set, memory reads go to the data memory (select 01) and memory writes go to connection-low (select 10), whatever bits 4..3 hold.
- R5: A write aimed at the data memory raises no memory request, changes no memory, and is still acknowledged one clock later.
- R6: With memory select 00 and no split, a memory-range transfer raises no request, is acknowledged one clock later, and a read returns 0.
- R7: A memory transfer holds its request, with stable address, select and data, until granted. Acknowledge falls the clock after the grant, and read data is the memory word present at the grant.
- R8: Acknowledge stays low while strobe and select stay active. It rises one clock after either one deasserts.
- R9: The read-data enable is high only while a read is acknowledged and still selected.
- R10: The message-mode output follows bit 6 of the control byte.
- R11: After reset the control byte is 0, acknowledge is high and no request or read enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Chip select, active low |
| bus_strobe | input | 1 | Data strobe, active high |
| bus_rd_wrn | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 6 | Register / channel address |
| bus_wdata | input | 8 | Write data from host |
| bus_rdata | output | 8 | Read data to host |
| bus_rdata_oe | output | 1 | Drive enable for read data |
| bus_ack_n | output | 1 | Transfer acknowledge, active low |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_sel | output | 2 | Target memory (01 data, 10 conn-low, 11 conn-high) |
| mem_addr | output | 8 | {stream, channel} |
| mem_wdata | output | 8 | Write data to memory |
| mem_gnt | input | 1 | Grant, one clock, in the processor slot |
| mem_rdata | input | 8 | Memory read word, valid with grant |
| msg_mode | output | 1 | Global message-mode flag |

## Verification
Local transfers (control byte, dropped data-memory writes, select 00) must show acknowledge low exactly one clock edge after the bus goes active. Memory transfers must show it three edges plus the scheduler's wait after that point, because the request state, the model's grant register and the capture into the acknowledge state each cost one edge. Acknowledge release is due one edge after strobe falls. Each transfer counts edges from its start, and all outputs are sampled one time unit after an edge. A request seen between start and acknowledge is matched against whether the transfer should reach memory. Read data and its enable are checked while the acknowledge is held.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int STRM_W  = 3;
    localparam int CHAN_W  = ADDR_W - 1;
    localparam int MADDR_W = STRM_W + CHAN_W;

    typedef enum logic [1:0] {
        MEM_NONE = 2'b00,
        MEM_DATA = 2'b01,
        MEM_CLO  = 2'b10,
        MEM_CHI  = 2'b11
    } mem_sel_e;

    typedef struct packed {
        logic              split;
        logic              msg;
        logic              spare;
        mem_sel_e          msel;
        logic [STRM_W-1:0] stream;
    } ctl_reg_t;

    typedef enum logic [1:0] {
        ACT_CTRL = 2'd0,
        ACT_MEM  = 2'd1,
        ACT_DROP = 2'd2
    } act_e;

    typedef struct packed {
        logic               we;
        mem_sel_e           sel;
        logic [MADDR_W-1:0] addr;
        logic [DATA_W-1:0]  wdata;
    } mem_cmd_t;

    function automatic mem_sel_e route_target(ctl_reg_t c, logic rd);
        if (c.split) return rd ? MEM_DATA : MEM_CLO;
        return c.msel;
    endfunction
endpackage

// File: rtl/cpu_ctl_reg.sv
module cpu_ctl_reg
    import cpu_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctl_reg_t          q
);
    ctl_reg_t d;

    always_comb begin
        d       = ctl_reg_t'(wdata);
        d.spare = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/cpu_addr_dec.sv
module cpu_addr_dec
    import cpu_port_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  ctl_reg_t           ctl,
    output act_e               act,
    output mem_sel_e           tgt,
    output logic [MADDR_W-1:0] maddr
);
    always_comb begin
        tgt   = route_target(ctl, rd);
        maddr = {ctl.stream, addr[CHAN_W-1:0]};
        if (!addr[ADDR_W-1])
            act = ACT_CTRL;
        else if (tgt == MEM_NONE || (tgt == MEM_DATA && !rd))
            act = ACT_DROP;
        else
            act = ACT_MEM;
    end
endmodule

// File: rtl/cpu_xfer_fsm.sv
module cpu_xfer_fsm
    import cpu_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               access,
    input  logic               rd,
    input  act_e               act,
    input  mem_sel_e           tgt,
    input  logic [MADDR_W-1:0] maddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  ctl_rd,
    input  logic               mem_gnt,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               ctl_we,
    output logic               mem_req,
    output mem_cmd_t           cmd,
    output logic               ack_n,
    output logic [DATA_W-1:0]  rdata,
    output logic               rdata_oe
);
    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_e;
    st_e  st;
    logic rd_q;

    assign ctl_we   = (st == S_IDLE) && access && (act == ACT_CTRL) && !rd;
    assign mem_req  = (st == S_WAIT);
    assign ack_n    = !(st == S_DONE);
    assign rdata_oe = (st == S_DONE) && rd_q && access;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            rd_q  <= 1'b0;
            rdata <= '0;
            cmd   <= '0;
        end else if (!access) begin
            st <= S_IDLE;
        end else begin
            case (st)
                S_IDLE: begin
                    rd_q <= rd;
                    case (act)
                        ACT_CTRL: begin
                            rdata <= ctl_rd;
                            st    <= S_DONE;
                        end
                        ACT_MEM: begin
                            cmd <= '{we: !rd, sel: tgt, addr: maddr, wdata: wdata};
                            st  <= S_WAIT;
                        end
                        default: begin
                            rdata <= '0;
                            st    <= S_DONE;
                        end
                    endcase
                end
                S_WAIT: if (mem_gnt) begin
                    rdata <= rd_q ? mem_rdata : '0;
                    st    <= S_DONE;
                end
                default: st <= S_DONE;
            endcase
        end
    end
endmodule

// File: rtl/cpu_port_ctl.sv
module cpu_port_ctl
    import cpu_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel_n,
    input  logic               bus_strobe,
    input  logic               bus_rd_wrn,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rdata_oe,
    output logic               bus_ack_n,
    output logic               mem_req,
    output logic               mem_we,
    output logic [1:0]         mem_sel,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_gnt,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               msg_mode
);
    logic               access;
    logic               ctl_we;
    ctl_reg_t           ctl_q;
    act_e               act;
    mem_sel_e           tgt;
    logic [MADDR_W-1:0] maddr;
    mem_cmd_t           cmd;

    assign access = !bus_sel_n && bus_strobe;

    cpu_ctl_reg u_reg (
        .clk(clk), .rst(rst), .we(ctl_we), .wdata(bus_wdata), .q(ctl_q)
    );

    cpu_addr_dec u_dec (
        .addr(bus_addr), .rd(bus_rd_wrn), .ctl(ctl_q),
        .act(act), .tgt(tgt), .maddr(maddr)
    );

    cpu_xfer_fsm u_fsm (
        .clk(clk), .rst(rst), .access(access), .rd(bus_rd_wrn),
        .act(act), .tgt(tgt), .maddr(maddr), .wdata(bus_wdata),
        .ctl_rd(DATA_W'(ctl_q)), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .ctl_we(ctl_we), .mem_req(mem_req), .cmd(cmd), .ack_n(bus_ack_n),
        .rdata(bus_rdata), .rdata_oe(bus_rdata_oe)
    );

    assign mem_we    = cmd.we;
    assign mem_sel   = cmd.sel;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;
    assign msg_mode  = ctl_q.msg;
endmodule

// File: rtl/cpu_port_chk.sv
module cpu_port_chk
    import cpu_port_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_sel_n,
    input logic               bus_strobe,
    input logic               bus_rd_wrn,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_ack_n,
    input logic               bus_rdata_oe,
    input logic               mem_req,
    input logic               mem_we,
    input logic [1:0]         mem_sel,
    input logic [MADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic               mem_gnt,
    input logic               split
);
    logic access;
    assign access = !bus_sel_n && bus_strobe;

    // R8
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        !access |=> bus_ack_n);

    // R9
    rd_oe_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_oe |-> (!bus_ack_n && access && bus_rd_wrn));

    // R5
    no_dm_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !(mem_we && mem_sel == 2'b01));

    // R4
    split_route_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && split) |-> (mem_sel == (mem_we ? 2'b10 : 2'b01)));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt && access) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_sel) && $stable(mem_wdata)));

    // R2
    ctrl_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (access && !bus_addr[ADDR_W-1] && bus_ack_n && !mem_req) |=> !bus_ack_n);
endmodule

bind cpu_port_ctl cpu_port_chk u_chk (
    .clk(clk), .rst(rst), .bus_sel_n(bus_sel_n), .bus_strobe(bus_strobe),
    .bus_rd_wrn(bus_rd_wrn), .bus_addr(bus_addr), .bus_ack_n(bus_ack_n),
    .bus_rdata_oe(bus_rdata_oe), .mem_req(mem_req), .mem_we(mem_we),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .split(ctl_q.split)
);

// File: tb/cpu_port_ctl_bench.sv
`timescale 1ns/1ps
module cpu_port_ctl_bench;
    localparam int GNT_WAIT = 2;
    localparam int NV = 22;

    logic       clk = 1'b0;
    logic       rst;
    logic       sel_n, strobe, rd_wrn;
    logic [5:0] addr;
    logic [7:0] wdata, rdata, mem_wdata, mem_rdata;
    logic       rdata_oe, ack_n, mem_req, mem_we, mem_gnt, msg_mode;
    logic [1:0] mem_sel;
    logic [7:0] mem_addr;

    logic [7:0] dm  [256];
    logic [7:0] clo [256];
    logic [7:0] chi [256];
    int         cnt;
    int         checks = 0;
    int         fails  = 0;

    always #2.5 clk = ~clk;

    cpu_port_ctl u_cpu_port_ctl (
        .clk(clk), .rst(rst), .bus_sel_n(sel_n), .bus_strobe(strobe),
        .bus_rd_wrn(rd_wrn), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .bus_rdata_oe(rdata_oe), .bus_ack_n(ack_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .msg_mode(msg_mode)
    );

    // Memory scheduler model: grants after GNT_WAIT idle clocks of request.
    always_comb begin
        case (mem_sel)
            2'b01:   mem_rdata = dm[mem_addr];
            2'b10:   mem_rdata = clo[mem_addr];
            2'b11:   mem_rdata = chi[mem_addr];
            default: mem_rdata = 8'h00;
        endcase
    end

    always @(posedge clk) begin
        if (rst) begin
            mem_gnt <= 1'b0;
            cnt     <= 0;
        end else begin
            mem_gnt <= mem_req && !mem_gnt && (cnt == GNT_WAIT);
            cnt     <= (mem_req && !mem_gnt) ? cnt + 1 : 0;
            if (mem_gnt && mem_we) begin
                if (mem_sel == 2'b10) clo[mem_addr] <= mem_wdata;
                if (mem_sel == 2'b11) chi[mem_addr] <= mem_wdata;
                if (mem_sel == 2'b01) dm[mem_addr]  <= mem_wdata;
            end
        end
    end

    // {rd, addr, wdata, expected read, memory expected}
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 6'h00, 8'h12, 8'h00, 1'b0},  // R2 CR: conn-low, stream 2
        {1'b0, 6'h25, 8'hA5, 8'h00, 1'b1},  // R3 write CLO ch5
        {1'b1, 6'h25, 8'h00, 8'hA5, 1'b1},  // R3 read back
        {1'b0, 6'h00, 8'h1A, 8'h00, 1'b0},  // R2 CR: conn-high
        {1'b0, 6'h25, 8'h07, 8'h00, 1'b1},  // R3
        {1'b1, 6'h25, 8'h00, 8'h07, 1'b1},  // R3
        {1'b0, 6'h00, 8'h0A, 8'h00, 1'b0},  // R2 CR: data memory
        {1'b1, 6'h25, 8'h00, 8'h1F, 1'b1},  // R3 dm[0x45]
        {1'b0, 6'h25, 8'hFF, 8'h00, 1'b0},  // R5 dropped write
        {1'b1, 6'h25, 8'h00, 8'h1F, 1'b1},  // R5 unchanged
        {1'b1, 6'h1F, 8'h00, 8'h0A, 1'b0},  // R1 any low bits
        {1'b0, 6'h00, 8'h91, 8'h00, 1'b0},  // R4 split on
        {1'b0, 6'h23, 8'h3C, 8'h00, 1'b1},  // R4 write -> CLO
        {1'b1, 6'h23, 8'h00, 8'h79, 1'b1},  // R4 read <- DM
        {1'b0, 6'h00, 8'h11, 8'h00, 1'b0},  // R4 split off
        {1'b1, 6'h23, 8'h00, 8'h3C, 1'b1},  // R4 CLO held write
        {1'b0, 6'h00, 8'h03, 8'h00, 1'b0},  // R6 select 00
        {1'b0, 6'h20, 8'h55, 8'h00, 1'b0},  // R6
        {1'b1, 6'h20, 8'h00, 8'h00, 1'b0},  // R6
        {1'b0, 6'h0C, 8'h7B, 8'h00, 1'b0},  // R1 R10 CR via other addr
        {1'b1, 6'h00, 8'h00, 8'h5B, 1'b0},  // R1 spare bit reads 0
        {1'b1, 6'h3F, 8'h00, 8'h00, 1'b1}   // R3 CHI stream 3 ch31
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic r, input logic [5:0] a, input logic [7:0] wd,
                        input logic [7:0] exp, input logic mem);
        int  lat;
        bit  saw;
        lat = 0;
        saw = 0;
        @(negedge clk);
        sel_n = 1'b0; strobe = 1'b1; rd_wrn = r; addr = a; wdata = wd;
        do begin
            @(posedge clk); #1;
            lat++;
            if (mem_req) saw = 1;
        end while (ack_n && lat < 40);
        check(lat == (mem ? GNT_WAIT + 3 : 1), mem ? "R7 latency" : "R2/R5/R6 latency", lat,
              mem ? GNT_WAIT + 3 : 1);
        check(saw == mem, "R5/R6 request", saw, mem);
        if (r) check(rdata == exp, "R1/R3/R4 read data", rdata, exp);
        check(rdata_oe == r, "R9 oe", rdata_oe, r);
        repeat (2) @(posedge clk);
        #1 check(!ack_n, "R8 ack held", ack_n, 0);
        @(negedge clk);
        strobe = 1'b0;
        @(posedge clk); #1;
        check(ack_n && !rdata_oe, "R8 release", {ack_n, rdata_oe}, 2);
        @(negedge clk);
        sel_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            dm[i]  = 8'(i) ^ 8'h5A;
            clo[i] = 8'h00;
            chi[i] = 8'h00;
        end
        rst = 1'b1; sel_n = 1'b1; strobe = 1'b0; rd_wrn = 1'b1;
        addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        // R11
        check(ack_n && !mem_req && !rdata_oe && !msg_mode, "R11 reset outputs",
              {ack_n, mem_req, rdata_oe, msg_mode}, 8);
        @(negedge clk) rst = 1'b0;
        xfer(1'b1, 6'h00, 8'h00, 8'h00, 1'b0);  // R11 control byte cleared

        for (int v = 0; v < NV; v++) begin
            xfer(VEC[v][23], VEC[v][22:17], VEC[v][16:9], VEC[v][8:1], VEC[v][0]);
        end

        #1 check(msg_mode == 1'b1, "R10 msg_mode set", msg_mode, 1);
        xfer(1'b0, 6'h00, 8'h13, 8'h00, 1'b0);
        #1 check(msg_mode == 1'b0, "R10 msg_mode clear", msg_mode, 0);
        // R5 the dropped write left dm untouched at the port level
        xfer(1'b0, 6'h00, 8'h0A, 8'h00, 1'b0);
        xfer(1'b1, 6'h25, 8'h00, 8'h1F, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule